// File: doc/BRIEF.md
# Range-Invalidating Translation Cache

This block is a small fully associative cache of address translations. Each slot holds a virtual page number kept at 4 KB resolution, a physical page number, a 16-bit address-space identifier, a global flag, the granule size and table level the translation was built with, and an XS attribute. A lookup port answers in the same cycle with a hit flag and the physical page of the lowest-numbered matching slot. The match respects the page size that the slot's granule and level imply. A fill port writes one slot at an index chosen by the caller.

A maintenance port accepts a 128-bit range-invalidate operand together with an exclude-XS flag. Several tests qualify the invalidation of a slot: whether its address lies in a computed range, whether its identifier matches or it is global, whether its granule matches, the level hint, and the XS filter. The controller is a three-state machine. In IDLE it accepts a command (IDLE to SCAN) and a fill. In SCAN it visits one slot per cycle and clears the slot when the slot qualifies. After the last slot it moves from SCAN to FINISH. FINISH pulses done for one cycle and returns to IDLE. While the machine is outside IDLE, busy is high. During that time new commands and fills are refused and lookups report a miss.

Top module: `range_tlb`

## Requirements
- R1: After reset every slot is empty, busy and done are low, and every lookup misses.
- R2: A fill in IDLE writes the slot at the fill index. A lookup then hits when the slot is valid, its identifier equals the lookup identifier or it is global, and the virtual page numbers agree above the page-size bits. Those bits are 0/9/18 for a 4 KB granule at level 3/2/1, 2/13/24 for 16 KB, and 4/17/30 for 64 KB. The lowest matching index supplies the physical page. A fill while busy is high has no effect.
- R3: A command is accepted only in IDLE. Busy then stays high for ENTRIES+1 cycles, and done is high in the last of them only. A command presented while busy is ignored.
- R4: While busy is high, the lookup port reports a miss.
- R5: The range starts at operand bits 107:64 (address bits 55:12) inclusive. Its length is (NUM+1)·2^(5·SCALE+1) granules, with NUM at bits 43:39 and SCALE at bits 45:44, and the end is exclusive. A slot is in range when its stored page number lies in that interval.
- R6: A non-global slot is cleared only if its identifier equals operand bits 63:48. A global slot in range is cleared whatever the operand identifier is.
- R7: Operand bits 47:46 give the granule: 01 is 4 KB, 10 is 16 KB, 11 is 64 KB. A slot built with another granule is left untouched. Code 00 clears nothing.
- R8: The level hint at bits 38:37 works as follows. Value 00 matches any level. Values 01, 10 and 11 clear only slots at level 1, 2 and 3 respectively.
- R9: With a 16 KB granule and LARGE_ADDR=0, hint 01 is treated as 00.
- R10: With exclude-XS set, slots whose XS attribute is set are not cleared. With it clear, XS has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_vpn | input | 44 | Lookup virtual page number (address bits 55:12) |
| lk_asid | input | 16 | Lookup address-space identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 40 | Physical page of the hitting slot |
| fill_en | input | 1 | Write one slot |
| fill_idx | input | IDX_W | Slot index to write |
| fill_vpn | input | 44 | Virtual page number to store |
| fill_ppn | input | 40 | Physical page number to store |
| fill_asid | input | 16 | Identifier to store |
| fill_global | input | 1 | Global flag to store |
| fill_gran | input | 2 | Granule code to store |
| fill_level | input | 2 | Table level (1 to 3) to store |
| fill_xs | input | 1 | XS attribute to store |
| inv_valid | input | 1 | Range-invalidate request |
| inv_op | input | 128 | Range-invalidate operand |
| inv_excl_xs | input | 1 | Skip slots with XS set |
| inv_busy | output | 1 | Invalidation in progress |
| inv_done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its defaults: ENTRIES=16 and LARGE_ADDR=0. The 16 slots leave room for translations of every granule and level at once, plus a duplicate to show lookup priority. LARGE_ADDR=0 makes the 16 KB hint demotion observable. Range edges are probed on both sides of the base and of the exclusive end. SCALE=3 with NUM=31 on a 64 KB granule drives the widest span the end-address arithmetic must hold.

// File: rtl/rtlb_pkg.sv
package rtlb_pkg;
    localparam int VPN_W   = 44;
    localparam int PPN_W   = 40;
    localparam int ASID_W  = 16;
    localparam int OP_W    = 128;
    localparam int RANGE_W = VPN_W + 1;

    localparam logic [1:0] GR_RSVD = 2'b00;
    localparam logic [1:0] GR_4K   = 2'b01;
    localparam logic [1:0] GR_16K  = 2'b10;
    localparam logic [1:0] GR_64K  = 2'b11;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [ASID_W-1:0] asid;
        logic              glb;
        logic [1:0]        gran;
        logic [1:0]        lvl;
        logic              xs;
    } tlb_ent_t;

    typedef struct packed {
        logic [VPN_W-1:0]   base;
        logic [RANGE_W-1:0] lim;
        logic [ASID_W-1:0]  asid;
        logic [1:0]         gran;
        logic [1:0]         hint;
        logic               excl_xs;
    } inv_cmd_t;

    // Extra page-number bits of one granule relative to 4 KB.
    function automatic logic [4:0] gran_shift(input logic [1:0] g);
        unique case (g)
            GR_16K:  return 5'd2;
            GR_64K:  return 5'd4;
            default: return 5'd0;
        endcase
    endfunction

    // Page-number bits covered by a block at the given granule and level.
    function automatic logic [4:0] page_shift(input logic [1:0] g, input logic [1:0] l);
        logic [4:0] per;
        logic [4:0] lv;
        unique case (g)
            GR_16K:  per = 5'd11;
            GR_64K:  per = 5'd13;
            default: per = 5'd9;
        endcase
        unique case (l)
            2'd1:    lv = 5'd2;
            2'd2:    lv = 5'd1;
            default: lv = 5'd0;
        endcase
        return gran_shift(g) + per * lv;
    endfunction
endpackage

// File: rtl/rtlb_op_decode.sv
module rtlb_op_decode
    import rtlb_pkg::*;
#(
    parameter bit LARGE_ADDR = 1'b0
) (
    input  logic [OP_W-1:0] op,
    input  logic            excl_xs,
    output inv_cmd_t        cmd
);
    localparam int SPAN_W = 30;

    logic [4:0]        num;
    logic [1:0]        scale;
    logic [1:0]        ttl;
    logic [1:0]        gran;
    logic [4:0]        exp_amt;
    logic [SPAN_W-1:0] granules;
    logic [SPAN_W-1:0] span4k;

    always_comb begin
        num      = op[43:39];
        scale    = op[45:44];
        ttl      = op[38:37];
        gran     = op[47:46];
        exp_amt  = 5'(scale) * 5'd5 + 5'd1;
        granules = (SPAN_W'(num) + SPAN_W'(1)) << exp_amt;
        span4k   = granules << gran_shift(gran);

        cmd.base    = op[107:64];
        cmd.lim     = {1'b0, op[107:64]} + RANGE_W'(span4k);
        cmd.asid    = op[63:48];
        cmd.gran    = gran;
        cmd.excl_xs = excl_xs;
        if (gran == GR_16K && !LARGE_ADDR && ttl == 2'b01)
            cmd.hint = 2'b00;
        else
            cmd.hint = ttl;
    end
endmodule

// File: rtl/rtlb_inv_match.sv
module rtlb_inv_match
    import rtlb_pkg::*;
(
    input  tlb_ent_t ent,
    input  inv_cmd_t cmd,
    output logic     hit
);
    logic in_range;
    logic owner_ok;
    logic shape_ok;
    logic xs_ok;

    always_comb begin
        in_range = ({1'b0, ent.vpn} >= {1'b0, cmd.base}) && ({1'b0, ent.vpn} < cmd.lim);
        owner_ok = ent.glb || (ent.asid == cmd.asid);
        shape_ok = (cmd.gran != GR_RSVD) && (ent.gran == cmd.gran)
                && ((cmd.hint == 2'b00) || (cmd.hint == ent.lvl));
        xs_ok    = !(cmd.excl_xs && ent.xs);
        hit      = ent.valid && in_range && owner_ok && shape_ok && xs_ok;
    end
endmodule

// File: rtl/rtlb_lookup.sv
module rtlb_lookup
    import rtlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  tlb_ent_t          ents [ENTRIES],
    input  logic [VPN_W-1:0]  va,
    input  logic [ASID_W-1:0] asid,
    input  logic              stall,
    output logic              hit,
    output logic [PPN_W-1:0]  ppn
);
    logic [ENTRIES-1:0] slot_hit;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic [4:0]       sh;
        logic [VPN_W-1:0] mask;
        always_comb begin
            sh          = page_shift(ents[i].gran, ents[i].lvl);
            mask        = {VPN_W{1'b1}} << sh;
            slot_hit[i] = ents[i].valid
                       && ((ents[i].vpn & mask) == (va & mask))
                       && (ents[i].glb || ents[i].asid == asid);
        end
    end

    always_comb begin
        hit = 1'b0;
        ppn = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (slot_hit[i]) begin
                hit = !stall;
                ppn = ents[i].ppn;
            end
        end
        if (stall) ppn = '0;
    end
endmodule

// File: rtl/range_tlb.sv
module range_tlb
    import rtlb_pkg::*;
#(
    parameter int ENTRIES    = 16,
    parameter bit LARGE_ADDR = 1'b0,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_global,
    input  logic [1:0]        fill_gran,
    input  logic [1:0]        fill_level,
    input  logic              fill_xs,
    input  logic              inv_valid,
    input  logic [OP_W-1:0]   inv_op,
    input  logic              inv_excl_xs,
    output logic              inv_busy,
    output logic              inv_done
);
    typedef enum logic [1:0] { S_IDLE, S_SCAN, S_FIN } state_t;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    state_t           state, state_nx;
    tlb_ent_t         ents_q [ENTRIES];
    inv_cmd_t         cmd_q, cmd_dec;
    logic [IDX_W-1:0] scan_idx;
    logic             clr_hit;
    logic             accept;
    logic             fill_fire;
    tlb_ent_t         fill_ent;

    rtlb_op_decode #(.LARGE_ADDR(LARGE_ADDR)) u_dec (
        .op      (inv_op),
        .excl_xs (inv_excl_xs),
        .cmd     (cmd_dec)
    );

    rtlb_inv_match u_match (
        .ent (ents_q[scan_idx]),
        .cmd (cmd_q),
        .hit (clr_hit)
    );

    rtlb_lookup #(.ENTRIES(ENTRIES)) u_look (
        .ents  (ents_q),
        .va    (lk_vpn),
        .asid  (lk_asid),
        .stall (inv_busy),
        .hit   (lk_hit),
        .ppn   (lk_ppn)
    );

    always_comb begin
        accept    = (state == S_IDLE) && inv_valid;
        fill_fire = (state == S_IDLE) && fill_en && (int'(fill_idx) < ENTRIES);
        fill_ent  = '{valid: 1'b1, vpn: fill_vpn, ppn: fill_ppn, asid: fill_asid,
                      glb: fill_global, gran: fill_gran, lvl: fill_level, xs: fill_xs};
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (accept) state_nx = S_SCAN;
            S_SCAN: if (scan_idx == LAST_IDX) state_nx = S_FIN;
            S_FIN:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Outputs
    always_comb begin
        inv_busy = (state != S_IDLE);
        inv_done = (state == S_FIN);
    end

    // Command latch and scan pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            scan_idx <= '0;
        end else begin
            if (accept) begin
                cmd_q    <= cmd_dec;
                scan_idx <= '0;
            end else if (state == S_SCAN && scan_idx != LAST_IDX) begin
                scan_idx <= scan_idx + 1'b1;
            end
        end
    end

    // Slot storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ents_q[i] <= '0;
        end else begin
            if (fill_fire) ents_q[fill_idx] <= fill_ent;
            if (state == S_SCAN && clr_hit) ents_q[scan_idx].valid <= 1'b0;
        end
    end

    // Checks
    p_start_needs_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inv_busy) |-> $past(inv_valid));
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |=> !inv_done);
    p_done_ends_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |=> !inv_busy);
    p_stall_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inv_busy |-> !lk_hit);
    p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SCAN && clr_hit) |=> !ents_q[$past(scan_idx)].valid);
    p_rsvd_gran_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SCAN && cmd_q.gran == GR_RSVD) |-> !clr_hit);
    p_xs_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SCAN && cmd_q.excl_xs && ents_q[scan_idx].xs) |-> !clr_hit);
endmodule

// File: tb/range_tlb_bench.sv
`timescale 1ns/1ps
module range_tlb_bench;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [43:0]  lk_vpn = '0;
    logic [15:0]  lk_asid = '0;
    logic         lk_hit;
    logic [39:0]  lk_ppn;
    logic         fill_en = 1'b0;
    logic [3:0]   fill_idx = '0;
    logic [43:0]  fill_vpn = '0;
    logic [39:0]  fill_ppn = '0;
    logic [15:0]  fill_asid = '0;
    logic         fill_global = 1'b0;
    logic [1:0]   fill_gran = '0;
    logic [1:0]   fill_level = '0;
    logic         fill_xs = 1'b0;
    logic         inv_valid = 1'b0;
    logic [127:0] inv_op = '0;
    logic         inv_excl_xs = 1'b0;
    logic         inv_busy;
    logic         inv_done;

    always #2.5 clk = ~clk;

    range_tlb u_range_tlb (.*);

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state
    logic        m_v [N];
    logic [43:0] m_vpn [N];
    logic [39:0] m_ppn [N];
    logic [15:0] m_as [N];
    logic        m_g [N];
    logic [1:0]  m_gr [N];
    logic [1:0]  m_lv [N];
    logic        m_xs [N];
    int          m_cnt = 0;

    function automatic int pshift(logic [1:0] g, logic [1:0] l);
        int gs  = (g == 2) ? 2 : (g == 3) ? 4 : 0;
        int per = (g == 2) ? 11 : (g == 3) ? 13 : 9;
        int lv  = (l == 0) ? 3 : int'(l);
        return gs + per * (3 - lv);
    endfunction

    function automatic logic [127:0] mk_op(longint base, int asid, int tg, int sc, int num, int ttl);
        logic [127:0] o = '0;
        o[107:64] = base[43:0];
        o[63:48]  = 16'(asid);
        o[47:46]  = 2'(tg);
        o[45:44]  = 2'(sc);
        o[43:39]  = 5'(num);
        o[38:37]  = 2'(ttl);
        return o;
    endfunction

    task automatic model_inv(logic [127:0] op, logic excl);
        int tg = int'(op[47:46]);
        int hint = int'(op[38:37]);
        int gs = (tg == 2) ? 2 : (tg == 3) ? 4 : 0;
        longint unsigned base = longint'(op[107:64]);
        longint unsigned len, lim;
        if (tg == 0) return;
        if (tg == 2 && hint == 1) hint = 0;
        len = longint'(int'(op[43:39]) + 1) * (64'd1 << (5 * int'(op[45:44]) + 1)) * (64'd1 << gs);
        lim = base + len;
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && int'(m_gr[i]) == tg && (hint == 0 || hint == int'(m_lv[i]))
                && !(excl && m_xs[i]) && (m_g[i] || m_as[i] == op[63:48])
                && longint'(m_vpn[i]) >= base && longint'(m_vpn[i]) < lim)
                m_v[i] = 1'b0;
        end
    endtask

    task automatic step(string tag);
        logic e_hit = 1'b0;
        logic [39:0] e_ppn = '0;
        logic e_busy, e_done;
        #1;
        e_busy = (m_cnt > 0);
        e_done = (m_cnt == 1);
        if (!e_busy) begin
            for (int i = N - 1; i >= 0; i--) begin
                int sh = pshift(m_gr[i], m_lv[i]);
                if (m_v[i] && ((m_vpn[i] >> sh) == (lk_vpn >> sh)) && (m_g[i] || m_as[i] == lk_asid)) begin
                    e_hit = 1'b1;
                    e_ppn = m_ppn[i];
                end
            end
        end
        n_cmp++;
        if (lk_hit !== e_hit || (e_hit && lk_ppn !== e_ppn) || inv_busy !== e_busy || inv_done !== e_done) begin
            n_bad++;
            $display("FAIL %s: hit/ppn/busy/done actual %b/%h/%b/%b expected %b/%h/%b/%b",
                     tag, lk_hit, lk_ppn, inv_busy, inv_done, e_hit, e_ppn, e_busy, e_done);
        end
        @(posedge clk);
        if (m_cnt > 0) begin
            m_cnt--;
        end else begin
            if (fill_en) begin
                m_v[fill_idx] = 1'b1;  m_vpn[fill_idx] = fill_vpn; m_ppn[fill_idx] = fill_ppn;
                m_as[fill_idx] = fill_asid; m_g[fill_idx] = fill_global;
                m_gr[fill_idx] = fill_gran; m_lv[fill_idx] = fill_level; m_xs[fill_idx] = fill_xs;
            end
            if (inv_valid) begin
                model_inv(inv_op, inv_excl_xs);
                m_cnt = N + 1;
            end
        end
        @(negedge clk);
    endtask

    task automatic fill(int idx, longint vpn, longint ppn, int asid, bit g, int gr, int lv, bit xs);
        fill_en = 1'b1; fill_idx = 4'(idx); fill_vpn = vpn[43:0]; fill_ppn = ppn[39:0];
        fill_asid = 16'(asid); fill_global = g; fill_gran = 2'(gr); fill_level = 2'(lv); fill_xs = xs;
        step("R2 fill");
        fill_en = 1'b0;
    endtask

    task automatic look(longint vpn, int asid, string tag);
        lk_vpn = vpn[43:0];
        lk_asid = 16'(asid);
        step(tag);
    endtask

    task automatic inv(logic [127:0] op, bit excl, string tag);
        inv_valid = 1'b1; inv_op = op; inv_excl_xs = excl;
        step(tag);
        inv_valid = 1'b0;
        while (m_cnt > 0) step(tag);
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_as[i] = 0;
            m_g[i] = 0; m_gr[i] = 0; m_lv[i] = 0; m_xs[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        look(44'h100, 5, "R1");
        look(44'h0, 0, "R1");

        // R2: fills of every shape, then lookups
        fill(0, 'h100, 'hA0, 5, 0, 1, 3, 0);
        fill(1, 'h104, 'hA1, 6, 0, 1, 3, 0);
        fill(2, 'h108, 'hA2, 9, 1, 1, 3, 0);
        fill(3, 'h10A, 'hA3, 5, 0, 1, 3, 1);
        fill(4, 'h200, 'hA4, 5, 0, 1, 2, 0);
        fill(5, 'h4000, 'hA5, 5, 0, 2, 3, 0);
        fill(6, 'h8000, 'hA6, 5, 0, 3, 3, 0);
        fill(7, 'h1000000, 'hA7, 5, 0, 2, 1, 0);
        fill(8, 'h100, 'hB0, 5, 0, 1, 3, 0);
        fill(10, 'h400, 'hAA, 5, 0, 1, 2, 0);
        look('h100, 5, "R2 priority");
        look('h3FF, 5, "R2 4K level2");
        look('h3FF, 6, "R2 asid miss");
        look('h4003, 5, "R2 16K");
        look('h800F, 5, "R2 64K");
        look('h1234567, 5, "R2 16K level1");
        look('h108, 77, "R2 global");

        // R5/R6: range edges and identifier
        inv(mk_op('h100, 5, 1, 0, 3, 0), 0, "R5 R6 range");
        look('h100, 5, "R5 base cleared");
        look('h104, 6, "R6 other asid kept");
        look('h108, 9, "R5 end exclusive");
        inv(mk_op('h104, 7, 1, 0, 4, 0), 0, "R6 global");
        look('h108, 9, "R6 global cleared");
        look('h104, 6, "R6 nonglobal kept");
        look('h10A, 5, "R5 nonglobal kept");

        // R3: command while busy ignored; R2: fill while busy refused
        inv_valid = 1'b1; inv_op = mk_op('h0, 99, 1, 0, 0, 0); inv_excl_xs = 1'b0;
        step("R3 start");
        inv_op = mk_op('h104, 6, 1, 0, 0, 0);
        fill_en = 1'b1; fill_idx = 4'd9; fill_vpn = 44'h300; fill_ppn = 40'hC9;
        fill_asid = 16'd5; fill_global = 1'b0; fill_gran = 2'd1; fill_level = 2'd3; fill_xs = 1'b0;
        while (m_cnt > 0) step("R3 R4 busy");
        inv_valid = 1'b0; fill_en = 1'b0;
        look('h104, 6, "R3 ignored command");
        look('h300, 5, "R2 refused fill");

        // R7: reserved granule and granule mismatch
        inv(mk_op('h4000, 5, 0, 1, 31, 0), 0, "R7 reserved");
        look('h4000, 5, "R7 reserved kept");
        inv(mk_op('h4000, 5, 3, 0, 0, 0), 0, "R7 mismatch");
        look('h4000, 5, "R7 mismatch kept");

        // R8: level hint
        inv(mk_op('h400, 5, 1, 0, 0, 3), 0, "R8 hint3");
        look('h400, 5, "R8 level2 kept");
        inv(mk_op('h400, 5, 1, 0, 0, 2), 0, "R8 hint2");
        look('h400, 5, "R8 level2 cleared");

        // R9: 16K hint 01 demoted to any level
        inv(mk_op('h4000, 5, 2, 0, 0, 1), 0, "R9 demote");
        look('h4000, 5, "R9 level3 cleared");
        look('h1000000, 5, "R9 level1 outside kept");

        // R10: XS filter
        inv(mk_op('h10A, 5, 1, 0, 0, 0), 1, "R10 exclude");
        look('h10A, 5, "R10 xs kept");
        inv(mk_op('h10A, 5, 1, 0, 0, 0), 0, "R10 normal");
        look('h10A, 5, "R10 xs cleared");

        // R5: widest span, below-base slot first
        inv(mk_op('h8001, 5, 3, 3, 31, 0), 0, "R5 below base");
        look('h8000, 5, "R5 below base kept");
        inv(mk_op('h0, 5, 3, 3, 31, 0), 0, "R5 wide");
        look('h8000, 5, "R5 wide cleared");
        look('h1000000, 5, "R7 wide other gran kept");
        look('h200, 5, "R7 wide 4K kept");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule